// File: doc/BRIEF.md
# Outbound PCI Window Address Translator

This block turns CPU-side physical addresses that land in a low PCI memory aperture into PCI bus addresses. The aperture begins at local address 0x10000000 and is 0x0C000000 bytes long. It is divided into three fixed 64 MB windows. Each window has its own 6-bit upper-address field. All three fields sit in a single 32-bit map register, which software writes and reads through a simple register port.

A lookup works like this. The CPU address is presented with a valid strobe. The block picks the window the address falls in and replaces address bits [31:26] with that window's field. The low 26 bits pass through unchanged. One clock later the block returns the PCI address, a hit flag and a high-region flag. The high-region flag is copied from a separate bit of the map register. Addresses outside the aperture produce no hit and a zero address.

Top module: `pciwin_xlate`

## Requirements
- R1: After reset the map register reads zero, and `pci_hit`, `pci_high` and `pci_addr` are all zero.
- R2: A write stores `cfg_wdata[18:0]` in the map register. A read returns those bits in `cfg_rdata[18:0]`, with `cfg_rdata[31:19]` always zero.
- R3: Window selection uses these fields of the map register:
  - addresses 0x10000000–0x13FFFFFF use bits [5:0];
  - addresses 0x14000000–0x17FFFFFF use bits [11:6];
  - addresses 0x18000000–0x1BFFFFFF use bits [17:12].
- R4: For a hit, `pci_addr[31:26]` equals the selected 6-bit field and `pci_addr[25:0]` equals `cpu_addr[25:0]`.
- R5: An address below 0x10000000 or at or above 0x1C000000 gives `pci_hit`=0, `pci_high`=0 and `pci_addr`=0.
- R6: Results are registered. Outputs reflect the address sampled with `cpu_valid`=1 at one rising edge and appear just after that edge. When `cpu_valid`=0 at an edge, all three outputs are zero after it.
- R7: `pci_high` equals map register bit 18 on a hit and is zero otherwise.
- R8: A lookup sampled at the same edge as a map write uses the old map value. Lookups at later edges use the new value.
- R9: The edge addresses of the aperture and its windows decode exactly:
  - 0x0FFFFFFF misses and 0x1C000000 misses;
  - 0x10000000 and 0x13FFFFFF select window 0;
  - 0x14000000 selects window 1;
  - 0x1BFFFFFF selects window 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Map register write enable |
| cfg_wdata | input | 32 | Map register write data |
| cfg_rdata | output | 32 | Map register read data |
| cpu_valid | input | 1 | CPU address valid strobe |
| cpu_addr | input | 32 | CPU physical address |
| pci_addr | output | 32 | Translated PCI address, zero on a miss |
| pci_hit | output | 1 | Address fell inside the aperture |
| pci_high | output | 1 | High PCI region flag for this hit |

## Verification
The bench targets several corner cases, each with the failure it exposes:
- Window edges (0x13FFFFFF/0x14000000, 0x0FFFFFFF, 0x1BFFFFFF, 0x1C000000). An off-by-one decode would send the last 64 MB of the aperture to the wrong field, or claim an address just outside it.
- Distinct, non-zero fields per window, plus random map values. A design that swapped field slices or shifted them by a bit would show a wrong upper PCI address.
- A map write issued in the same cycle as a lookup. A design that forwards write data early, instead of using the registered map, would return the new field one lookup too soon.
- Idle cycles after a hit. A design that holds outputs when `cpu_valid` falls would keep a stale hit flag asserted.

// File: rtl/pciwin_pkg.sv
package pciwin_pkg;
   // number of map register bits: all window fields plus the high-region flag
   function automatic int map_bit_count(input int num_win, input int field_w);
      return num_win * field_w + 1;
   endfunction
endpackage

// File: rtl/pciwin_mapreg.sv
module pciwin_mapreg #(
   parameter int DATA_W   = 32,
   parameter int MAP_BITS = 19
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [MAP_BITS-1:0] map_q,
   output logic [DATA_W-1:0]   rd_data
);
   generate
      if (MAP_BITS > DATA_W) begin : g_bad_width
         $error("map register wider than data port");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map_q <= '0;
      else if (wr_en) map_q <= wr_data[MAP_BITS-1:0];
   end

   generate
      if (MAP_BITS == DATA_W) begin : g_full
         assign rd_data = map_q;
      end else begin : g_pad
         assign rd_data = {{(DATA_W-MAP_BITS){1'b0}}, map_q};
      end
   endgenerate
endmodule

// File: rtl/pciwin_decode.sv
module pciwin_decode #(
   parameter int ADDR_W    = 32,
   parameter int WIN_SHIFT = 26,
   parameter int NUM_WIN   = 3,
   parameter int BASE_IDX  = 4,
   localparam int FIELD_W  = ADDR_W - WIN_SHIFT
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic [NUM_WIN*FIELD_W-1:0] fields,
   output logic                       hit,
   output logic [ADDR_W-1:0]          xlat_addr
);
   logic [NUM_WIN-1:0] sel;
   logic [FIELD_W-1:0] upper;

   generate
      for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
         assign sel[gi] = (addr[ADDR_W-1:WIN_SHIFT] == FIELD_W'(BASE_IDX + gi));
      end
   endgenerate

   always_comb begin
      upper = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (sel[i]) upper = upper | fields[i*FIELD_W +: FIELD_W];
      end
   end

   assign hit       = |sel;
   assign xlat_addr = hit ? {upper, addr[WIN_SHIFT-1:0]} : '0;

   // at most one window may claim an address (R3)
   always_comb begin
      if (!$isunknown(sel)) begin
         assert_onehot_sel_R3: assert ($onehot0(sel))
            else $error("more than one window selected");
      end
   end
endmodule

// File: rtl/pciwin_outreg.sv
module pciwin_outreg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              hit_d,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic              high_d,
   output logic              hit_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic              high_q
);
   logic take;
   assign take = valid & hit_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q  <= 1'b0;
         addr_q <= '0;
         high_q <= 1'b0;
      end else begin
         hit_q  <= take;
         addr_q <= take ? addr_d : '0;
         high_q <= take & high_d;
      end
   end
endmodule

// File: rtl/pciwin_xlate.sv
module pciwin_xlate #(
   parameter int          ADDR_W    = 32,
   parameter int          WIN_SHIFT = 26,
   parameter int          NUM_WIN   = 3,
   parameter logic [31:0] APER_BASE = 32'h1000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cfg_rdata,
   input  logic              cpu_valid,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic [ADDR_W-1:0] pci_addr,
   output logic              pci_hit,
   output logic              pci_high
);
   import pciwin_pkg::*;

   localparam int FIELD_W  = ADDR_W - WIN_SHIFT;
   localparam int MAP_BITS = map_bit_count(NUM_WIN, FIELD_W);
   localparam int HIGH_BIT = MAP_BITS - 1;
   localparam int BASE_IDX = int'(APER_BASE >> WIN_SHIFT);
   localparam logic [ADDR_W-1:0] MAP_MASK = ADDR_W'((64'd1 << MAP_BITS) - 64'd1);

   generate
      if (WIN_SHIFT <= 0 || WIN_SHIFT >= ADDR_W) begin : g_bad_shift
         $error("WIN_SHIFT out of range");
      end
      if (MAP_BITS > ADDR_W) begin : g_bad_map
         $error("window fields do not fit one register");
      end
      if (BASE_IDX + NUM_WIN > (1 << FIELD_W)) begin : g_bad_base
         $error("aperture runs past the top of the address space");
      end
   endgenerate

   logic [MAP_BITS-1:0] map_q;
   logic                dec_hit;
   logic [ADDR_W-1:0]   dec_addr;

   pciwin_mapreg #(.DATA_W(ADDR_W), .MAP_BITS(MAP_BITS)) u_map (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
      .map_q(map_q), .rd_data(cfg_rdata)
   );

   pciwin_decode #(.ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .NUM_WIN(NUM_WIN),
                   .BASE_IDX(BASE_IDX)) u_dec (
      .addr(cpu_addr), .fields(map_q[NUM_WIN*FIELD_W-1:0]),
      .hit(dec_hit), .xlat_addr(dec_addr)
   );

   pciwin_outreg #(.ADDR_W(ADDR_W)) u_out (
      .clk(clk), .rst_n(rst_n), .valid(cpu_valid), .hit_d(dec_hit),
      .addr_d(dec_addr), .high_d(map_q[HIGH_BIT]),
      .hit_q(pci_hit), .addr_q(pci_addr), .high_q(pci_high)
   );

   assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> cfg_rdata == ($past(cfg_wdata) & MAP_MASK));

   assert_low_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid |=> (!pci_hit || pci_addr[WIN_SHIFT-1:0] == $past(cpu_addr[WIN_SHIFT-1:0])));

   assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pci_hit |-> (pci_addr == '0 && !pci_high));

   assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_valid |=> !pci_hit);

   assert_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pci_high |-> (pci_hit && cfg_rdata[HIGH_BIT]) || $past(cfg_we));
endmodule

// File: tb/pciwin_xlate_test.sv
module pciwin_xlate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        cpu_valid = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] pci_addr;
   logic        pci_hit;
   logic        pci_high;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   logic [31:0] model_map = '0;

   always #2.5 clk = ~clk;

   pciwin_xlate uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
      .pci_addr(pci_addr), .pci_hit(pci_hit), .pci_high(pci_high)
   );

   function automatic logic [31:0] exp_addr(input logic [31:0] m, input logic [31:0] a);
      int w = int'(a[31:26]) - 4;
      if (w < 0 || w > 2) return 32'h0;
      return {m[w*6 +: 6], a[25:0]};
   endfunction

   function automatic logic exp_hit(input logic [31:0] a);
      return (a >= 32'h1000_0000) && (a < 32'h1C00_0000);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_map(input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      model_map = v & 32'h0007_FFFF;
   endtask

   // drive one lookup, check outputs after the capturing edge
   task automatic lookup(input string req, input logic [31:0] a);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_addr = a;
      @(negedge clk);
      cpu_valid = 1'b0;
      chk({req, " hit"},  {31'b0, pci_hit},  {31'b0, exp_hit(a)});
      chk({req, " addr"}, pci_addr, exp_addr(model_map, a));
      chk({req, " high"}, {31'b0, pci_high}, {31'b0, exp_hit(a) & model_map[18]});
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rdata", cfg_rdata, 32'h0);
      chk("R1 hit", {31'b0, pci_hit}, 32'h0);
      chk("R1 addr", pci_addr, 32'h0);
      chk("R1 high", {31'b0, pci_high}, 32'h0);
      rst_n = 1'b1;

      // R2 readback with upper bits masked
      write_map(32'hFFFF_FFFF);
      chk("R2 readback all-ones", cfg_rdata, 32'h0007_FFFF);
      write_map(32'h0004_6105); // w0=5, w1=4, w2=6, high=1
      chk("R2 readback", cfg_rdata, 32'h0004_6105);

      // R3/R4/R7 one address per window
      lookup("R3 R4 R7 win0", 32'h1234_5678);
      lookup("R3 R4 win1", 32'h1555_AAAA);
      lookup("R3 R4 win2", 32'h1ABC_DEF0);
      // R9 boundaries
      lookup("R9 below", 32'h0FFF_FFFF);
      lookup("R9 base", 32'h1000_0000);
      lookup("R9 end win0", 32'h13FF_FFFF);
      lookup("R9 start win1", 32'h1400_0000);
      lookup("R9 top", 32'h1BFF_FFFF);
      lookup("R9 past top", 32'h1C00_0000);
      // R5 far misses
      lookup("R5 zero", 32'h0000_0000);
      lookup("R5 high addr", 32'hFFFF_FFFF);

      // R6 idle cycle after a hit clears outputs
      lookup("R6 hit", 32'h1800_0004);
      @(negedge clk);
      chk("R6 idle hit", {31'b0, pci_hit}, 32'h0);
      chk("R6 idle addr", pci_addr, 32'h0);

      // R8 write and lookup at the same edge use old map
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = 32'h0000_0FFF;
      cpu_valid = 1'b1; cpu_addr = 32'h1000_0010;
      @(negedge clk);
      cfg_we = 1'b0; cpu_valid = 1'b0;
      chk("R8 same-edge addr", pci_addr, exp_addr(model_map, 32'h1000_0010));
      chk("R8 same-edge high", {31'b0, pci_high}, {31'b0, model_map[18]});
      model_map = 32'h0000_0FFF;
      lookup("R8 next lookup", 32'h1000_0010);

      // random mix against the model
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a;
         if (i % 25 == 0) write_map($urandom());
         if ($urandom() % 4 != 0) a = 32'h1000_0000 + ($urandom() % 32'h0C00_0000);
         else a = $urandom();
         lookup("R3 R4 R5 R7 random", a);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule